// File: doc/BRIEF.md
# Dual Timer/Counter Unit

This block holds two independent timer/counter channels. Each channel keeps an 8-bit low count byte and an 8-bit high count byte. A channel advances either on a machine-cycle tick, made by dividing the system clock by 12, or on a falling edge of its external count pin. That pin is sampled once per machine cycle. A run bit starts and stops each channel. An optional gate pin can also hold the channel, which makes it possible to measure the width of a pulse on that pin.

Four count geometries can be chosen for each channel:
- a 13-bit counter;
- a 16-bit counter;
- an 8-bit counter that reloads itself from the high byte;
- a split mode on channel 0, which turns the channel into two 8-bit counters. In this mode the high byte of channel 0 uses the run bit and the overflow flag of channel 1.

A channel that rolls over from all ones to all zeros sets a sticky overflow flag. The flag is cleared when the interrupt for that channel is acknowledged. Software reaches six byte registers through a plain write/read port. A write to a register takes effect at the clock edge. A read is combinational.

Top module: `dual_tc_unit`

## Requirements
- R1: After reset, all six registers read 00h and both overflow flags are 0. The register addresses are: 0 mode, 1 control, 2 channel-0 low, 3 channel-0 high, 4 channel-1 low, 5 channel-1 high.
- R2: In timer operation (C/T=0), a running channel advances exactly once per 12 clocks. A channel whose run bit is 0 holds its count. The control bits are: 4 run0, 5 flag0, 6 run1, 7 flag1.
- R3: When the gate bit is 1, the channel counts only while its gate pin is high. The gate pin passes through a two-flop synchronizer.
- R4: In counter operation (C/T=1), the count advances once for each high-to-low transition of the count pin. The pin is sampled once per machine cycle, and a pin held high adds nothing.
- R5: In mode 00, the count is the high byte joined to the low 5 bits of the low byte. A carry out of those 5 bits increments the high byte. Bits 7..5 of the low byte are left unchanged. A roll-over from all ones sets the flag.
- R6: In mode 01, the two bytes form a 16-bit count. A step from FFFFh to 0000h sets the flag.
- R7: In mode 10, only the low byte counts. When it steps from FFh, it takes the value of the high byte and the flag is set.
- R8: In mode 11 on channel 0, the low byte is an 8-bit counter that uses channel 0's C/T, gate, run bit and flag. The high byte counts machine cycles whenever run1 is set, and its roll-over sets flag1. The roll-over of channel 1 itself does not set flag1 in this mode.
- R9: A channel in mode 11 on channel 1 holds its count.
- R10: A flag stays set until that channel's acknowledge strobe. One acknowledge cycle clears it. A control-register write in the same cycle has priority over the acknowledge, and the acknowledge has priority over a new hardware set.
- R11: A software write to a count byte in the same cycle as a hardware increment or reload wins.
- R12: The mode register reads back what was written. Bits 3..0 go to channel 0 and bits 7..4 to channel 1, each nibble laid out as gate, C/T, M1, M0 from its high bit down. Control bits 3..0 are plain storage. Software writes to the flag bits drive the flag outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| cntPin | input | 2 | External count pins, one per channel |
| gatePin | input | 2 | External gate pins, one per channel |
| intAck | input | 2 | Interrupt-acknowledge strobes, one per channel |
| ovfFlag | output | 2 | Overflow flags: bit 0 channel 0, bit 1 channel 1 |

## Verification
The bench starts a channel, lets it run for an exact number of machine cycles, and then freezes it by setting its gate bit while the gate pin is low. This exposes the following errors:
- an off-by-one in the prescaler, which shows up as a wrong final count;
- a 13-bit mode that carries at bit 7, or that clears the upper low-byte bits;
- a reload that loads zero instead of the high byte;
- a 16-bit roll-over that fails to set the flag.

In split mode, the bench checks two things. The high byte must follow run1 and flag1. Channel 1's own wrap must not raise flag1; a design that let it through would show a stray flag. The bench also checks that:
- a held-high count pin adds no counts;
- a write that collides with a tick keeps the written value;
- the acknowledge clears only its own flag.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_C0LO = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_C0HI = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_C1LO = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_C1HI = 3'd5;

  typedef enum logic [1:0] {
    GEO_13     = 2'b00,
    GEO_16     = 2'b01,
    GEO_RELOAD = 2'b10,
    GEO_SPLIT  = 2'b11
  } geo_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic inc0;    // channel 0 (or its low byte in split mode) steps
    logic inc0Hi;  // channel 0 high byte steps in split mode
    logic inc1;    // channel 1 steps
  } tcStrobe_t;
endpackage

// File: rtl/tc_ctrl.sv
module tc_ctrl
  import tc_pkg::*;
#(
  parameter int DIV = 12,
  parameter int SYNC_STAGES = 2,
  parameter int CHANNELS = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CHANNELS-1:0] cntPin,
  input  logic [CHANNELS-1:0] gatePin,
  input  logic [7:0]          modeReg,
  input  logic [7:0]          ctrlReg,
  output tcStrobe_t           strobe
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(DIV - 1);

  logic [PW-1:0] preCnt;
  logic tick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else if (preCnt == PRE_LAST) preCnt <= '0;
    else preCnt <= preCnt + PW'(1);
  end
  assign tick = (preCnt == PRE_LAST);

  logic [CHANNELS-1:0] chanInc;

  for (genvar g = 0; g < CHANNELS; g++) begin : chanG
    logic [SYNC_STAGES-1:0] cSync, gSync;
    logic sampCur, sampPrev, fallSeen, countEn, runOk;
    logic [3:0] nib;

    assign nib = modeReg[4*g +: 4];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cSync    <= '0;
        gSync    <= '0;
        sampCur  <= 1'b0;
        sampPrev <= 1'b0;
      end else begin
        cSync <= {cSync[SYNC_STAGES-2:0], cntPin[g]};
        gSync <= {gSync[SYNC_STAGES-2:0], gatePin[g]};
        if (tick) begin
          sampCur  <= cSync[SYNC_STAGES-1];
          sampPrev <= sampCur;
        end
      end
    end

    // high sample followed by low sample: count on the following tick
    assign fallSeen = sampPrev & ~sampCur;
    assign countEn  = nib[2] ? (tick & fallSeen) : tick;
    assign runOk    = ctrlReg[4 + 2*g] & (~nib[3] | gSync[SYNC_STAGES-1]);
    assign chanInc[g] = runOk & countEn;
  end

  always_comb begin
    strobe.inc0   = chanInc[0];
    strobe.inc1   = chanInc[1] & (geo_t'(modeReg[5:4]) != GEO_SPLIT);
    strobe.inc0Hi = tick & ctrlReg[6] & (geo_t'(modeReg[1:0]) == GEO_SPLIT);
  end
endmodule

// File: rtl/tc_datapath.sv
module tc_datapath
  import tc_pkg::*;
#(
  parameter int CHANNELS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  input  logic [1:0]        intAck,
  input  tcStrobe_t         strobe,
  output logic [7:0]        regRdData,
  output logic [7:0]        modeReg,
  output logic [7:0]        ctrlReg,
  output logic [7:0]        c0Lo,
  output logic [7:0]        c0Hi,
  output logic [7:0]        c1Lo,
  output logic [7:0]        c1Hi
);
  // returns {overflow, hi, lo} after one step in the given geometry
  function automatic logic [16:0] stepCount(input geo_t geo, input logic [7:0] lo,
                                            input logic [7:0] hi);
    logic [16:0] r;
    r = {1'b0, hi, lo};
    case (geo)
      GEO_13: begin
        if (lo[4:0] == 5'h1F) begin
          r = {hi == 8'hFF, hi + 8'd1, lo[7:5], 5'h00};
        end else begin
          r = {1'b0, hi, lo[7:5], lo[4:0] + 5'd1};
        end
      end
      GEO_16:     r = {({hi, lo} == 16'hFFFF), {hi, lo} + 16'd1};
      GEO_RELOAD: r = (lo == 8'hFF) ? {1'b1, hi, hi} : {1'b0, hi, lo + 8'd1};
      default:    r = {lo == 8'hFF, hi, lo + 8'd1};
    endcase
    return r;
  endfunction

  logic wrCtrl;
  assign wrCtrl = regWrEn && (regAddr == ADDR_CTRL);

  for (genvar g = 0; g < CHANNELS; g++) begin : chan
    localparam logic [ADDR_W-1:0] A_LO = ADDR_C0LO + ADDR_W'(2*g);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_C0HI + ADDR_W'(2*g);
    logic [7:0] loQ, hiQ, loN, hiN;
    logic incCh, ovfMain, ovfHi;
    logic [16:0] stepRes;

    assign incCh = (g == 0) ? strobe.inc0 : strobe.inc1;

    always_comb begin
      stepRes = stepCount(geo_t'(modeReg[4*g +: 2]), loQ, hiQ);
      loN = loQ;
      hiN = hiQ;
      ovfMain = 1'b0;
      ovfHi = 1'b0;
      if (incCh) {ovfMain, hiN, loN} = stepRes;
      if (g == 0 && strobe.inc0Hi) begin
        hiN   = hiQ + 8'd1;
        ovfHi = (hiQ == 8'hFF);
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        loQ <= '0;
        hiQ <= '0;
      end else begin
        loQ <= (regWrEn && regAddr == A_LO) ? regWrData : loN;
        hiQ <= (regWrEn && regAddr == A_HI) ? regWrData : hiN;
      end
    end
  end

  logic set0, set1, split0;
  assign split0 = (geo_t'(modeReg[1:0]) == GEO_SPLIT);
  assign set0 = chan[0].ovfMain;
  assign set1 = split0 ? chan[0].ovfHi : chan[1].ovfMain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
      ctrlReg <= '0;
    end else begin
      if (regWrEn && regAddr == ADDR_MODE) modeReg <= regWrData;
      if (wrCtrl) begin
        ctrlReg <= regWrData;
      end else begin
        if (intAck[0]) ctrlReg[5] <= 1'b0;
        else if (set0) ctrlReg[5] <= 1'b1;
        if (intAck[1]) ctrlReg[7] <= 1'b0;
        else if (set1) ctrlReg[7] <= 1'b1;
      end
    end
  end

  assign c0Lo = chan[0].loQ;
  assign c0Hi = chan[0].hiQ;
  assign c1Lo = chan[1].loQ;
  assign c1Hi = chan[1].hiQ;

  always_comb begin
    case (regAddr)
      ADDR_MODE: regRdData = modeReg;
      ADDR_CTRL: regRdData = ctrlReg;
      ADDR_C0LO: regRdData = c0Lo;
      ADDR_C0HI: regRdData = c0Hi;
      ADDR_C1LO: regRdData = c1Lo;
      ADDR_C1HI: regRdData = c1Hi;
      default:   regRdData = 8'h00;
    endcase
  end
endmodule

// File: rtl/dual_tc_unit.sv
module dual_tc_unit
  import tc_pkg::*;
#(
  parameter int DIV = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic [1:0] cntPin,
  input  logic [1:0] gatePin,
  input  logic [1:0] intAck,
  output logic [1:0] ovfFlag
);
  tcStrobe_t strobe;
  logic [7:0] modeReg, ctrlReg, c0Lo, c0Hi, c1Lo, c1Hi;

  tc_ctrl #(.DIV(DIV), .SYNC_STAGES(SYNC_STAGES), .CHANNELS(2)) uCtrl (
    .clk(clk), .rstN(rstN), .cntPin(cntPin), .gatePin(gatePin),
    .modeReg(modeReg), .ctrlReg(ctrlReg), .strobe(strobe)
  );

  tc_datapath #(.CHANNELS(2)) uDp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .intAck(intAck), .strobe(strobe),
    .regRdData(regRdData), .modeReg(modeReg), .ctrlReg(ctrlReg),
    .c0Lo(c0Lo), .c0Hi(c0Hi), .c1Lo(c1Lo), .c1Hi(c1Hi)
  );

  assign ovfFlag = {ctrlReg[7], ctrlReg[5]};
endmodule

// File: rtl/tc_checker.sv
module tc_checker
  import tc_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       regWrEn,
  input logic [2:0] regAddr,
  input logic [7:0] regWrData,
  input logic [1:0] intAck,
  input logic [1:0] ovfFlag,
  input logic [7:0] modeReg,
  input logic [7:0] ctrlReg,
  input logic [7:0] c0Lo,
  input logic [7:0] c0Hi,
  input logic [7:0] c1Lo,
  input logic [7:0] c1Hi,
  input tcStrobe_t  strobe
);
  assert_hold_stopped_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlReg[4] && !(regWrEn && regAddr == ADDR_C0LO)) |=> (c0Lo == $past(c0Lo)));

  assert_reload_R7: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg[1:0] == 2'b10 && strobe.inc0 && c0Lo == 8'hFF && !regWrEn && !intAck[0])
      |=> (c0Lo == $past(c0Hi) && ovfFlag[0]));

  assert_split_mask_R8: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg[1:0] == 2'b11 && !ovfFlag[1] && !(strobe.inc0Hi && c0Hi == 8'hFF) && !regWrEn)
      |=> !ovfFlag[1]);

  assert_ch1_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg[5:4] == 2'b11 && !(regWrEn && (regAddr == ADDR_C1LO || regAddr == ADDR_C1HI)))
      |=> ($stable(c1Lo) && $stable(c1Hi)));

  assert_ack0_R10: assert property (@(posedge clk) disable iff (!rstN)
    (intAck[0] && !(regWrEn && regAddr == ADDR_CTRL)) |=> !ovfFlag[0]);

  assert_ack1_R10: assert property (@(posedge clk) disable iff (!rstN)
    (intAck[1] && !(regWrEn && regAddr == ADDR_CTRL)) |=> !ovfFlag[1]);

  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_C0LO) |=> (c0Lo == $past(regWrData)));
endmodule

bind dual_tc_unit tc_checker uChk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .intAck(intAck), .ovfFlag(ovfFlag),
  .modeReg(modeReg), .ctrlReg(ctrlReg), .c0Lo(c0Lo), .c0Hi(c0Hi),
  .c1Lo(c1Lo), .c1Hi(c1Hi), .strobe(strobe)
);

// File: tb/sim_dual_tc_unit.sv
`timescale 1ns/100ps
module sim_dual_tc_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [1:0] cntPin = '0;
  logic [1:0] gatePin = '0;
  logic [1:0] intAck = '0;
  logic [1:0] ovfFlag;

  localparam logic [2:0] A_MODE = 3'd0, A_CTRL = 3'd1, A_C0LO = 3'd2,
                         A_C0HI = 3'd3, A_C1LO = 3'd4, A_C1HI = 3'd5;

  dual_tc_unit u0 (.*);

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  typedef struct packed {
    logic [7:0] mode;
    logic [7:0] hi;
    logic [7:0] lo;
    logic [7:0] ticks;
    logic [7:0] expHi;
    logic [7:0] expLo;
    logic       expFlag;
    logic [3:0] req;
  } vec_t;

  // channel 0 timer runs for an exact number of machine cycles
  localparam vec_t VECS [7] = '{
    '{8'h01, 8'hFF, 8'hFE, 8'd3, 8'h00, 8'h01, 1'b1, 4'd6},  // R6 wrap
    '{8'h01, 8'h12, 8'h34, 8'd5, 8'h12, 8'h39, 1'b0, 4'd2},  // R2 exact rate
    '{8'h00, 8'h12, 8'hFE, 8'd3, 8'h13, 8'hE1, 1'b0, 4'd5},  // R5 carry at bit 4
    '{8'h00, 8'hFF, 8'h1F, 8'd1, 8'h00, 8'h00, 1'b1, 4'd5},  // R5 wrap
    '{8'h02, 8'h80, 8'hFE, 8'd4, 8'h80, 8'h82, 1'b1, 4'd7},  // R7 reload
    '{8'h02, 8'h10, 8'h20, 8'd3, 8'h10, 8'h23, 1'b0, 4'd7},  // R7 no reload
    '{8'h03, 8'h55, 8'hFF, 8'd2, 8'h55, 8'h01, 1'b1, 4'd8}   // R8 low byte
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkEq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    regAddr = a;
    #0.2;
    d = regRdData;
  endtask

  // run with ctl for exactly k machine cycles, then freeze via gate bit
  task automatic runTicks(input logic [7:0] ctl, input logic [7:0] mode, input int k);
    wr(A_CTRL, ctl);
    repeat (12 * k - 2) @(negedge clk);
    wr(A_MODE, mode | 8'h08);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v2;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chkEq($sformatf("R1 reg %0d after reset", a), v, 0);
    end
    chkEq("R1 flags after reset", ovfFlag, 0);

    // vector table
    for (int i = 0; i < 7; i++) begin
      wr(A_CTRL, 8'h00);
      wr(A_MODE, VECS[i].mode);
      wr(A_C0HI, VECS[i].hi);
      wr(A_C0LO, VECS[i].lo);
      runTicks(8'h10, VECS[i].mode, int'(VECS[i].ticks));
      repeat (3) @(negedge clk);
      rd(A_C0LO, v);
      rd(A_C0HI, v2);
      chkEq($sformatf("R%0d vector %0d low", VECS[i].req, i), v, VECS[i].expLo);
      chkEq($sformatf("R%0d vector %0d high", VECS[i].req, i), v2, VECS[i].expHi);
      chkEq($sformatf("R%0d vector %0d flag0", VECS[i].req, i), ovfFlag[0], VECS[i].expFlag);
    end

    // R2 hold when run bit is 0
    wr(A_CTRL, 8'h00);
    wr(A_MODE, 8'h01);
    wr(A_C0LO, 8'h42);
    repeat (60) @(negedge clk);
    rd(A_C0LO, v);
    chkEq("R2 stopped channel holds", v, 8'h42);

    // R3 gate pin
    wr(A_C0LO, 8'h00);
    wr(A_C0HI, 8'h00);
    wr(A_MODE, 8'h09);
    wr(A_CTRL, 8'h10);
    repeat (60) @(negedge clk);
    rd(A_C0LO, v);
    chkEq("R3 gate low blocks counting", v, 0);
    gatePin[0] = 1'b1;
    repeat (120) @(negedge clk);
    gatePin[0] = 1'b0;
    repeat (30) @(negedge clk);
    rd(A_C0LO, v);
    chk(v >= 9 && v <= 11, "R3 gate high counts about 10", v, 10);

    // R4 counter mode: five falling edges
    wr(A_CTRL, 8'h00);
    wr(A_MODE, 8'h05);
    wr(A_C0LO, 8'h00);
    wr(A_C0HI, 8'h00);
    wr(A_CTRL, 8'h10);
    for (int p = 0; p < 5; p++) begin
      cntPin[0] = 1'b1;
      repeat (36) @(negedge clk);
      cntPin[0] = 1'b0;
      repeat (36) @(negedge clk);
    end
    repeat (48) @(negedge clk);
    rd(A_C0LO, v);
    chkEq("R4 five falling edges counted", v, 5);
    cntPin[0] = 1'b1;
    repeat (120) @(negedge clk);
    rd(A_C0LO, v);
    chkEq("R4 held-high pin adds nothing", v, 5);
    cntPin[0] = 1'b0;

    // R8 split: high byte follows run1, channel 1 wrap masked
    wr(A_CTRL, 8'h00);
    wr(A_MODE, 8'h13);
    wr(A_C0LO, 8'h33);
    wr(A_C0HI, 8'h10);
    wr(A_C1LO, 8'hFF);
    wr(A_C1HI, 8'hFF);
    wr(A_CTRL, 8'h40);
    repeat (24) @(negedge clk);
    rd(A_C0HI, v);
    rd(A_C1LO, v2);
    chkEq("R8 split high byte counts on run1", v, 8'h12);
    chkEq("R8 channel 1 keeps counting in split", v2, 8'h01);
    chkEq("R8 channel 1 wrap does not set flag1", ovfFlag[1], 0);
    wr(A_CTRL, 8'h00);
    rd(A_C0LO, v);
    chkEq("R8 low byte idle without run0", v, 8'h33);
    wr(A_C0HI, 8'hFE);
    wr(A_CTRL, 8'h40);
    repeat (24) @(negedge clk);
    rd(A_C0HI, v);
    chkEq("R8 split high byte wraps", v, 8'h00);
    chkEq("R8 high byte wrap sets flag1", ovfFlag[1], 1);

    // R9 channel 1 in mode 11 holds
    wr(A_CTRL, 8'h00);
    wr(A_MODE, 8'h31);
    wr(A_C1LO, 8'h34);
    wr(A_C1HI, 8'h12);
    wr(A_CTRL, 8'h40);
    repeat (60) @(negedge clk);
    rd(A_C1LO, v);
    rd(A_C1HI, v2);
    chkEq("R9 channel 1 mode 11 holds", {v2, v}, 16'h1234);
    chkEq("R9 no flag1 from held channel", ovfFlag[1], 0);

    // R12 register map
    wr(A_CTRL, 8'h00);
    wr(A_MODE, 8'hA5);
    rd(A_MODE, v);
    chkEq("R12 mode readback", v, 8'hA5);
    wr(A_MODE, 8'h00);
    wr(A_CTRL, 8'h0F);
    rd(A_CTRL, v);
    chkEq("R12 control low bits storage", v, 8'h0F);
    chkEq("R12 flags clear", ovfFlag, 0);
    wr(A_CTRL, 8'hA0);
    chkEq("R12 software flag write", ovfFlag, 2'b11);

    // R10 sticky flags and acknowledge
    repeat (30) @(negedge clk);
    chkEq("R10 flags sticky", ovfFlag, 2'b11);
    intAck[1] = 1'b1;
    @(negedge clk);
    intAck[1] = 1'b0;
    chkEq("R10 ack clears only flag1", ovfFlag, 2'b01);
    intAck[0] = 1'b1;
    @(negedge clk);
    intAck[0] = 1'b0;
    chkEq("R10 ack clears flag0", ovfFlag, 2'b00);

    // R11 software write beats a tick in the same cycle
    wr(A_MODE, 8'h01);
    wr(A_C0HI, 8'h00);
    wr(A_CTRL, 8'h10);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = A_C0LO; regWrData = 8'h77;
    repeat (30) @(negedge clk);
    regWrEn = 1'b0;
    rd(A_C0LO, v);
    chkEq("R11 write wins over increment", v, 8'h77);
    wr(A_CTRL, 8'h00);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule